// File: doc/BRIEF.md
# Threshold Trip Monitor

This block watches a stream of measurement samples, each tagged with the index of one of sixteen slots. Software programs a scan window with a first index and a last index. The block walks a scan pointer through that window, and the pointer tells the converter which slot to measure next. When a sample arrives for a slot inside the window, the block compares the value against that slot's low and high thresholds. Those thresholds come in as flat buses from a threshold table outside the block.

A sample below the low threshold latches a low-trip flag for that slot. A sample above the high threshold latches a high-trip flag. Flags stay set until software clears them.

Four 16-bit trip registers each pair eight enable bits with eight flag bits for the same eight slots. A flag drives the single interrupt line only while its enable is set. Software can also write a flag to 1, which forces an interrupt for test.

Top module: `tripmon`

## Requirements
- R1: A sample accepted for slot s sets that slot's low-trip flag when the value is strictly below the low threshold of slot s. The low threshold of slot s is `lo_thr_i[s*DATA_W +: DATA_W]`, and the comparison is unsigned. A value equal to the threshold sets nothing.
- R2: A sample accepted for slot s sets that slot's high-trip flag when the value is strictly above the high threshold of slot s. The high threshold of slot s is `hi_thr_i[s*DATA_W +: DATA_W]`. A value equal to the threshold sets nothing.
- R3: The trip registers sit at these addresses:
  - 0 holds the low trips of slots 0..7.
  - 1 holds the high trips of slots 0..7.
  - 2 holds the low trips of slots 8..15.
  - 3 holds the high trips of slots 8..15.

  In each register, bits 15:8 are the enables and bits 7:0 are the flags. Bit n of each field belongs to slot base+n, where base is 0 or 8. With `PIPE_CMP`=0, a flag reads back set right after the clock edge that accepts the sample.
- R4: `irq_o` is high exactly when at least one flag in any trip register has its enable bit set. A set flag with its enable cleared leaves `irq_o` low.
- R5: Flags stay set across later samples, whether those samples trip or not. A flag clears only when software writes 0 to that bit.
- R6: A register write loads bits 15:8 into the enables and bits 7:0 into the flags. Writing 1 to a flag sets it, and raises `irq_o` if that flag's enable is set.
- R7: Address 4 is the scan window register. Bits 11:8 hold the first index and bits 3:0 hold the last index. Bits 15:12 and 7:4 read as 0 and ignore writes.
- R8: Every `smp_vld_i` pulse advances `scan_slot_o`, which steps by one from the first index to the last index and then returns to the first. If the pointer is outside the window, it jumps to the first index. If first > last, the pointer stays on the first index.
- R9: If a hardware trip and a software write of 0 hit the same flag in one cycle, the flag ends up set.
- R10: A sample whose slot lies outside the window sets no flag. The window runs from first to last inclusive when first <= last, and is the first index alone when first > last.
- R11: After reset, all five registers read 0, `irq_o` is low and `scan_slot_o` is 0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample strobe, one cycle per sample |
| smp_slot_i | input | 4 | Slot index of the sample |
| smp_val_i | input | DATA_W | Sample value, unsigned |
| lo_thr_i | input | NUM_SLOTS*DATA_W | Low thresholds, slot s at s*DATA_W |
| hi_thr_i | input | NUM_SLOTS*DATA_W | High thresholds, slot s at s*DATA_W |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for both write and read |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the addressed register, combinational |
| scan_slot_o | output | 4 | Slot the scan pointer is on |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume several things about the inputs:
- `smp_vld_i` and `reg_wr_i` are driven to known values while out of reset.
- The threshold buses are steady while a sample is taken.
- The window fields do not change in the cycle a sample advances the pointer. The pointer check is released whenever the window changes.

The bench keeps to these conditions. It holds the thresholds constant from before reset release, drives every input half a period away from the sampling edge, and rewrites the window only while no sample is pending. It picks sample values at, one below and one above each threshold, so the strict comparisons are exercised.

// File: rtl/tripmon_pkg.sv
package tripmon_pkg;

   localparam int GROUP   = 8;
   localparam int REG_W   = 2 * GROUP;
   localparam int ADDR_W  = 3;
   localparam int LIST_W  = 4;

   typedef enum logic [ADDR_W-1:0] {
      A_LOW_A  = 3'd0,
      A_HIGH_A = 3'd1,
      A_LOW_B  = 3'd2,
      A_HIGH_B = 3'd3,
      A_LIST   = 3'd4
   } reg_addr_e;

   // window membership: inclusive range, or the first index alone when inverted
   function automatic logic slot_in_window(input logic [LIST_W-1:0] idx,
                                           input logic [LIST_W-1:0] first,
                                           input logic [LIST_W-1:0] last);
      if (first > last) return idx == first;
      return (idx >= first) && (idx <= last);
   endfunction

endpackage

// File: rtl/tripmon_scan.sv
module tripmon_scan
   import tripmon_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic [IDX_W-1:0] first_i,
   input  logic [IDX_W-1:0] last_i,
   output logic [IDX_W-1:0] slot_o
);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_d;
   logic             restart;

   initial begin
      if (IDX_W != LIST_W) $error("tripmon_scan: IDX_W must match the list field width");
   end

   always_comb begin
      restart = (first_i > last_i) || (ptr_q < first_i) || (ptr_q >= last_i);
      ptr_d   = restart ? first_i : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_d;
   end

   assign slot_o = ptr_q;

   // R8
   scan_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> (!$stable(first_i) || !$stable(last_i) ||
                 slot_in_window(slot_o, first_i, last_i)));

   // R8
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(slot_o));

endmodule

// File: rtl/tripmon_cmp.sv
module tripmon_cmp #(
   parameter int NUM_SLOTS = 16,
   parameter int DATA_W    = 12,
   parameter int IDX_W     = 4,
   parameter bit PIPE      = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        vld_i,
   input  logic [IDX_W-1:0]            idx_i,
   input  logic [DATA_W-1:0]           val_i,
   input  logic [NUM_SLOTS*DATA_W-1:0] lo_thr_i,
   input  logic [NUM_SLOTS*DATA_W-1:0] hi_thr_i,
   output logic [NUM_SLOTS-1:0]        lo_hit_o,
   output logic [NUM_SLOTS-1:0]        hi_hit_o
);

   logic              vld_s;
   logic [IDX_W-1:0]  idx_s;
   logic [DATA_W-1:0] val_s;
   logic [DATA_W-1:0] lo_sel;
   logic [DATA_W-1:0] hi_sel;
   logic              lo_trip;
   logic              hi_trip;

   initial begin
      if (NUM_SLOTS > (1 << IDX_W)) $error("tripmon_cmp: IDX_W too narrow for NUM_SLOTS");
   end

   generate
      if (PIPE) begin : g_pipe
         logic              vld_q;
         logic [IDX_W-1:0]  idx_q;
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               idx_q <= '0;
               val_q <= '0;
            end else begin
               vld_q <= vld_i;
               if (vld_i) begin
                  idx_q <= idx_i;
                  val_q <= val_i;
               end
            end
         end
         assign vld_s = vld_q;
         assign idx_s = idx_q;
         assign val_s = val_q;
      end else begin : g_direct
         assign vld_s = vld_i;
         assign idx_s = idx_i;
         assign val_s = val_i;
      end
   endgenerate

   // one shared comparator pair behind a threshold mux
   always_comb begin
      lo_sel  = lo_thr_i[int'(idx_s)*DATA_W +: DATA_W];
      hi_sel  = hi_thr_i[int'(idx_s)*DATA_W +: DATA_W];
      lo_trip = val_s < lo_sel;
      hi_trip = val_s > hi_sel;
   end

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
         assign lo_hit_o[s] = vld_s && lo_trip && (idx_s == IDX_W'(s));
         assign hi_hit_o[s] = vld_s && hi_trip && (idx_s == IDX_W'(s));
      end
   endgenerate

   // R1
   lo_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lo_hit_o));

   // R2
   hi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hi_hit_o));

   // R2
   no_double_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|lo_hit_o) |-> ((lo_hit_o & hi_hit_o) == '0 || (lo_sel > hi_sel)));

endmodule

// File: rtl/tripmon_bank.sv
module tripmon_bank
   import tripmon_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic [GROUP-1:0] set_i,
   output logic [REG_W-1:0] value_o,
   output logic             irq_o
);

   logic [GROUP-1:0] en_q;
   logic [GROUP-1:0] flag_q;
   logic [GROUP-1:0] flag_d;

   // hardware set is OR-ed after the software value, so a trip is never lost
   always_comb begin
      flag_d = (wr_i ? wdata_i[GROUP-1:0] : flag_q) | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         flag_q <= '0;
      end else begin
         if (wr_i) en_q <= wdata_i[REG_W-1:GROUP];
         flag_q <= flag_d;
      end
   end

   assign value_o = {en_q, flag_q};
   assign irq_o   = |(en_q & flag_q);

   // R9
   hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R6
   sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((flag_q & $past(wdata_i[GROUP-1:0])) == $past(wdata_i[GROUP-1:0])));

   // R6
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(value_o[REG_W-1:GROUP]));

endmodule

// File: rtl/tripmon.sv
module tripmon
   import tripmon_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int DATA_W    = 12,
   parameter bit PIPE_CMP  = 1'b0,
   localparam int IDX_W    = $clog2(NUM_SLOTS),
   localparam int NUM_BANKS = NUM_SLOTS / GROUP,
   localparam int THR_W    = NUM_SLOTS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld_i,
   input  logic [IDX_W-1:0]  smp_slot_i,
   input  logic [DATA_W-1:0] smp_val_i,
   input  logic [THR_W-1:0]  lo_thr_i,
   input  logic [THR_W-1:0]  hi_thr_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic [IDX_W-1:0]  scan_slot_o,
   output logic              irq_o
);

   initial begin
      if (NUM_SLOTS != 16) $error("tripmon: register layout fixes NUM_SLOTS at 16");
      if (DATA_W < 1 || DATA_W > 32) $error("tripmon: DATA_W out of range");
   end

   logic [LIST_W-1:0]    first_q;
   logic [LIST_W-1:0]    last_q;
   logic                 accept;
   logic [NUM_SLOTS-1:0] lo_hit;
   logic [NUM_SLOTS-1:0] hi_hit;
   logic [REG_W-1:0]     lo_val  [NUM_BANKS];
   logic [REG_W-1:0]     hi_val  [NUM_BANKS];
   logic [NUM_BANKS-1:0] lo_irq;
   logic [NUM_BANKS-1:0] hi_irq;

   // scan window register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
      end else if (reg_wr_i && reg_addr_i == A_LIST) begin
         first_q <= reg_wdata_i[11:8];
         last_q  <= reg_wdata_i[3:0];
      end
   end

   assign accept = smp_vld_i && slot_in_window(smp_slot_i, first_q, last_q);

   tripmon_scan #(.IDX_W(IDX_W)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (smp_vld_i),
      .first_i (first_q),
      .last_i  (last_q),
      .slot_o  (scan_slot_o)
   );

   tripmon_cmp #(
      .NUM_SLOTS (NUM_SLOTS),
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .PIPE      (PIPE_CMP)
   ) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (accept),
      .idx_i    (smp_slot_i),
      .val_i    (smp_val_i),
      .lo_thr_i (lo_thr_i),
      .hi_thr_i (hi_thr_i),
      .lo_hit_o (lo_hit),
      .hi_hit_o (hi_hit)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         tripmon_bank u_lo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (reg_wr_i && reg_addr_i == ADDR_W'(2*b)),
            .wdata_i (reg_wdata_i),
            .set_i   (lo_hit[b*GROUP +: GROUP]),
            .value_o (lo_val[b]),
            .irq_o   (lo_irq[b])
         );
         tripmon_bank u_hi (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (reg_wr_i && reg_addr_i == ADDR_W'(2*b+1)),
            .wdata_i (reg_wdata_i),
            .set_i   (hi_hit[b*GROUP +: GROUP]),
            .value_o (hi_val[b]),
            .irq_o   (hi_irq[b])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == A_LIST) begin
         reg_rdata_o[11:8] = first_q;
         reg_rdata_o[3:0]  = last_q;
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (reg_addr_i == ADDR_W'(2*b))   reg_rdata_o = lo_val[b];
         if (reg_addr_i == ADDR_W'(2*b+1)) reg_rdata_o = hi_val[b];
      end
   end

   assign irq_o = (|lo_irq) | (|hi_irq);

   // R7
   list_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == A_LIST) |-> (reg_rdata_o[15:12] == 4'd0 && reg_rdata_o[7:4] == 4'd0));

   // R4
   irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i < A_LIST && (reg_rdata_o[15:8] & reg_rdata_o[7:0]) != 8'd0) |-> irq_o);

   // R10
   out_of_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld_i && !slot_in_window(smp_slot_i, first_q, last_q) && !PIPE_CMP)
         |-> (lo_hit == '0 && hi_hit == '0));

endmodule

// File: tb/tripmon_bench.sv
module tripmon_bench;
   import tripmon_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 16;
   localparam int DW = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_vld = 1'b0;
   logic [3:0]        smp_slot = '0;
   logic [DW-1:0]     smp_val = '0;
   logic [NS*DW-1:0]  lo_thr;
   logic [NS*DW-1:0]  hi_thr;
   logic              reg_wr = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [15:0]       reg_wdata = '0;
   logic [15:0]       reg_rdata;
   logic [3:0]        scan_slot;
   logic              irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tripmon u_tripmon (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_vld_i   (smp_vld),
      .smp_slot_i  (smp_slot),
      .smp_val_i   (smp_val),
      .lo_thr_i    (lo_thr),
      .hi_thr_i    (hi_thr),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .scan_slot_o (scan_slot),
      .irq_o       (irq)
   );

   // slot, value, expect low, expect high; thresholds lo=100+10s, hi=2000+10s
   localparam logic [17:0] VEC [0:7] = '{
      {4'd2,  12'd119,  2'b10},
      {4'd2,  12'd120,  2'b00},
      {4'd9,  12'd2091, 2'b01},
      {4'd9,  12'd2090, 2'b00},
      {4'd15, 12'd0,    2'b10},
      {4'd0,  12'd4095, 2'b01},
      {4'd7,  12'd1000, 2'b00},
      {4'd8,  12'd179,  2'b10}
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic sample(input logic [3:0] s, input logic [DW-1:0] v);
      @(negedge clk);
      smp_vld = 1'b1; smp_slot = s; smp_val = v;
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic clear_all();
      for (int a = 0; a < 4; a++) wr(3'(a), 16'h0000);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] r;
      for (int i = 0; i < NS; i++) begin
         lo_thr[i*DW +: DW] = DW'(100 + 10*i);
         hi_thr[i*DW +: DW] = DW'(2000 + 10*i);
      end
      repeat (3) @(negedge clk);
      // R11 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), r);
         check("R11 reset register", r, 16'h0000);
      end
      check("R11 reset irq", {15'd0, irq}, 16'd0);
      check("R11 reset scan", {12'd0, scan_slot}, 16'd0);
      rst_n = 1'b1;

      // R1 R2 R3 vector table, full window
      wr(A_LIST, 16'h000F);
      foreach (VEC[k]) begin
         logic [3:0] s;
         logic [2:0] base;
         s = VEC[k][17:14];
         base = (s >= 4'd8) ? 3'd2 : 3'd0;
         clear_all();
         sample(s, VEC[k][13:2]);
         rd(base, r);
         check("R1 R3 low flag", r, VEC[k][1] ? 16'(1 << s[2:0]) : 16'h0000);
         rd(base + 3'd1, r);
         check("R2 R3 high flag", r, VEC[k][0] ? 16'(1 << s[2:0]) : 16'h0000);
      end

      // R4 masked then enabled
      clear_all();
      sample(4'd9, 12'd3000);
      #1 check("R4 masked flag no irq", {15'd0, irq}, 16'd0);
      wr(A_HIGH_B, 16'h0202);
      #1 check("R4 enabled irq", {15'd0, irq}, 16'd1);
      // R5 stays set over quiet samples
      sample(4'd9, 12'd1000);
      sample(4'd3, 12'd1000);
      rd(A_HIGH_B, r);
      check("R5 sticky flag", r, 16'h0202);
      wr(A_HIGH_B, 16'h0200);
      rd(A_HIGH_B, r);
      check("R5 software clear", r, 16'h0200);
      #1 check("R5 irq drops", {15'd0, irq}, 16'd0);

      // R6 software set forces irq
      clear_all();
      wr(A_LOW_A, 16'h0101);
      rd(A_LOW_A, r);
      check("R6 forced flag", r, 16'h0101);
      #1 check("R6 forced irq", {15'd0, irq}, 16'd1);

      // R9 same-cycle trip and clear
      @(negedge clk);
      smp_vld = 1'b1; smp_slot = 4'd0; smp_val = 12'd5;
      reg_wr = 1'b1; reg_addr = A_LOW_A; reg_wdata = 16'h0100;
      @(negedge clk);
      smp_vld = 1'b0; reg_wr = 1'b0;
      rd(A_LOW_A, r);
      check("R9 hardware set wins", r, 16'h0101);

      // R7 list register reserved bits
      wr(A_LIST, 16'hFFFF);
      rd(A_LIST, r);
      check("R7 reserved read zero", r, 16'h0F0F);

      // R8 scan walk 3..5
      clear_all();
      wr(A_LIST, 16'h0305);
      sample(4'd3, 12'd1000); #1 check("R8 scan first", {12'd0, scan_slot}, 16'd3);
      sample(4'd3, 12'd1000); #1 check("R8 scan step", {12'd0, scan_slot}, 16'd4);
      sample(4'd3, 12'd1000); #1 check("R8 scan last", {12'd0, scan_slot}, 16'd5);
      sample(4'd3, 12'd1000); #1 check("R8 scan wrap", {12'd0, scan_slot}, 16'd3);

      // R10 outside window ignored, inside taken
      sample(4'd9, 12'd0);
      rd(A_LOW_B, r);
      check("R10 out of window ignored", r, 16'h0000);
      sample(4'd4, 12'd0);
      rd(A_LOW_A, r);
      check("R10 in window taken", r, 16'h0010);

      // R8 R10 inverted window: start slot only
      clear_all();
      wr(A_LIST, 16'h0902);
      sample(4'd2, 12'd0);
      #1 check("R8 inverted holds start", {12'd0, scan_slot}, 16'd9);
      rd(A_LOW_A, r);
      check("R10 inverted excludes end", r, 16'h0000);
      sample(4'd9, 12'd0);
      #1 check("R8 inverted stays", {12'd0, scan_slot}, 16'd9);
      rd(A_LOW_B, r);
      check("R10 inverted start taken", r, 16'h0002);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule